// File: doc/BRIEF.md
# Two-Stage Cascaded Dual-Clock FIFO

This block is a 16-bit first-in first-out buffer whose writer and reader run on unrelated clocks. Its capacity is not a power of two. Two power-of-two asynchronous stages are joined in series instead of one larger memory. The front stage (2048 words) is filled from the write clock. The back stage (1024 words) is drained on the read clock. A relay engine on a third, intermediate clock moves words from the front stage into the back stage.

Each stage passes its gray-coded pointers across clock domains through two-flop synchronisers, so its flags are conservative. Full may assert early and release late. Empty behaves the same way. Neither flag is ever wrong in the unsafe direction. The relay is a three-state machine:

- RL_IDLE: nothing is held. The transition IDLE->FETCH pops the front stage when it reports not empty.
- RL_FETCH: the memory output is captured into a one-word holding register. The transition FETCH->HOLD is unconditional.
- RL_HOLD: the held word is pushed into the back stage once that stage reports not full. On the push, HOLD->FETCH is taken if the front stage still has data (the next pop is issued in the same cycle). Otherwise HOLD->IDLE is taken. While the back stage is full, the machine stays in HOLD and keeps the word.

To the outside, full comes from the front stage's write side and empty from the back stage's read side. A single asynchronous reset is released synchronously in each of the three domains.

Top module: `cfifo_cascade`

## Requirements
- R1: Words leave the read port in exactly the order they were accepted at the write port, with no loss and no duplication.
- R2: A write attempted while full is low... more precisely, a write attempted while `full` is 1 is discarded: it never appears at the read port.
- R3: A read attempted while `empty` is 1 is ignored: `rd_data` keeps its previous value and no word is consumed.
- R4: With reads stalled, the writer can place exactly 3073 words (2048 + 1024 + one held in the relay) before `full` stays asserted. `full` is never 0 while 3073 words are unread.
- R5: `empty` is never 0 while no unread word exists.
- R6: After reset, `full` is 0, `empty` is 1 and `rd_data` is 0.
- R7: A read accepted on a rising `rd_clk` edge (rd_en=1, empty=0) presents its word on `rd_data` from that same edge. The value is held until the next accepted read.
- R8: A single word written into an idle, empty FIFO becomes readable (`empty` falls) within 40 `rd_clk` cycles.
- R9: The relay pops the front stage only when it is not empty, pushes the back stage only when it is not full, and keeps its held word while the back stage is full. Every accepted word therefore crosses both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| relay_clk | input | 1 | Intermediate clock for the relay engine |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| wr_en | input | 1 | Write request, accepted when `full` is 0 |
| wr_data | input | 16 | Word to write |
| full | output | 1 | No space at the write port (wr_clk domain) |
| rd_en | input | 1 | Read request, accepted when `empty` is 0 |
| rd_data | output | 16 | Word from the most recent accepted read |
| empty | output | 1 | No word available at the read port (rd_clk domain) |

## Verification
A write is taken on the `wr_clk` rising edge at which `full` is 0. A read taken on an `rd_clk` rising edge has its word on `rd_data` right after that edge. The bench drives on falling edges, so it compares `rd_data` at the next falling edge against a queue model, and it does this on every read clock, including the clocks with no accepted read. The flags cross domains with a latency of several cycles, so their exact timing is not predicted. Instead, each flag is checked every cycle against the model occupancy in the safe direction. The one timed flag result, the first-word latency, is checked against a bound of 40 read cycles, together with the exact fill capacity reached after the flags have settled.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
    typedef enum logic [1:0] {
        RL_IDLE  = 2'd0,
        RL_FETCH = 2'd1,
        RL_HOLD  = 2'd2
    } relay_state_t;
endpackage

// File: rtl/cfifo_rstsync.sv
module cfifo_rstsync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic stg;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stg    <= 1'b0;
            srst_n <= 1'b0;
        end else begin
            stg    <= 1'b1;
            srst_n <= stg;
        end
    end
endmodule

// File: rtl/cfifo_sync.sv
module cfifo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cfifo_stage.sv
module cfifo_stage #(
    parameter int DW = 16,
    parameter int AW = 10
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          full,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rgray_at_w;
    logic [PW-1:0] rbin, rgray, wgray_at_r;
    logic [PW-1:0] wbin_nx, rbin_nx;
    logic          wr_ok, rd_ok;

    assign full    = (wgray == {~rgray_at_w[PW-1:PW-2], rgray_at_w[PW-3:0]});
    assign empty   = (rgray == wgray_at_r);
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign wbin_nx = wbin + 1'b1;
    assign rbin_nx = rbin + 1'b1;

    always_ff @(posedge wclk) begin
        if (wr_ok) mem[wbin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_ok) begin
            wbin  <= wbin_nx;
            wgray <= to_gray(wbin_nx);
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
            rdata <= '0;
        end else if (rd_ok) begin
            rbin  <= rbin_nx;
            rgray <= to_gray(rbin_nx);
            rdata <= mem[rbin[AW-1:0]];
        end
    end

    cfifo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_at_w));
    cfifo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_at_r));

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && full) |=> $stable(wbin)); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && empty) |=> ($stable(rbin) && $stable(rdata))); // R3
    AST_WPTR_ONE_BIT: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R1
    AST_RPTR_ONE_BIT: assert property (@(posedge rclk) disable iff (!rrst_n)
        $countones(rgray ^ $past(rgray)) <= 1); // R1
endmodule

// File: rtl/cfifo_relay.sv
module cfifo_relay
    import cfifo_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_empty,
    output logic          src_pop,
    input  logic [DW-1:0] src_data,
    input  logic          dst_full,
    output logic          dst_push,
    output logic [DW-1:0] dst_data
);
    relay_state_t state, state_nx;
    logic [DW-1:0] hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RL_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 hold <= '0;
        else if (state == RL_FETCH) hold <= src_data;
    end

    always_comb begin
        state_nx = state;
        src_pop  = 1'b0;
        dst_push = 1'b0;
        unique case (state)
            RL_IDLE: begin
                if (!src_empty) begin
                    src_pop  = 1'b1;
                    state_nx = RL_FETCH;
                end
            end
            RL_FETCH: state_nx = RL_HOLD;
            RL_HOLD: begin
                if (!dst_full) begin
                    dst_push = 1'b1;
                    if (!src_empty) begin
                        src_pop  = 1'b1;
                        state_nx = RL_FETCH;
                    end else begin
                        state_nx = RL_IDLE;
                    end
                end
            end
            default: state_nx = RL_IDLE;
        endcase
    end

    assign dst_data = hold;

    AST_POP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> !src_empty); // R9
    AST_PUSH_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        dst_push |-> !dst_full); // R9
    AST_FETCH_THEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RL_FETCH) |=> (state == RL_HOLD)); // R9
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RL_HOLD && dst_full) |=> (state == RL_HOLD && $stable(hold))); // R9
endmodule

// File: rtl/cfifo_cascade.sv
module cfifo_cascade #(
    parameter int DW  = 16,
    parameter int AW1 = 11,
    parameter int AW2 = 10
) (
    input  logic          wr_clk,
    input  logic          relay_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty
);
    logic          wrst_n, xrst_n, rrst_n;
    logic          s1_empty, s1_pop, s2_full, s2_push;
    logic [DW-1:0] s1_q, s2_d;

    cfifo_rstsync u_rs_w (.clk(wr_clk),    .arst_n(rst_n), .srst_n(wrst_n));
    cfifo_rstsync u_rs_x (.clk(relay_clk), .arst_n(rst_n), .srst_n(xrst_n));
    cfifo_rstsync u_rs_r (.clk(rd_clk),    .arst_n(rst_n), .srst_n(rrst_n));

    cfifo_stage #(.DW(DW), .AW(AW1)) u_front (
        .wclk(wr_clk), .wrst_n(wrst_n), .wr_en(wr_en), .wdata(wr_data), .full(full),
        .rclk(relay_clk), .rrst_n(xrst_n), .rd_en(s1_pop), .rdata(s1_q), .empty(s1_empty)
    );

    cfifo_relay #(.DW(DW)) u_relay (
        .clk(relay_clk), .rst_n(xrst_n),
        .src_empty(s1_empty), .src_pop(s1_pop), .src_data(s1_q),
        .dst_full(s2_full), .dst_push(s2_push), .dst_data(s2_d)
    );

    cfifo_stage #(.DW(DW), .AW(AW2)) u_back (
        .wclk(relay_clk), .wrst_n(xrst_n), .wr_en(s2_push), .wdata(s2_d), .full(s2_full),
        .rclk(rd_clk), .rrst_n(rrst_n), .rd_en(rd_en), .rdata(rd_data), .empty(empty)
    );
endmodule

// File: tb/sim_cfifo_cascade.sv
`timescale 1ns/100ps
module sim_cfifo_cascade;
    localparam int CAP = 3073;

    logic        wr_clk = 0, relay_clk = 0, rd_clk = 0, rst_n = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [15:0] wr_data = 0;
    logic        full, empty;
    logic [15:0] rd_data;

    always #2.5 wr_clk    = ~wr_clk;
    always #3.5 relay_clk = ~relay_clk;
    always #3.1 rd_clk    = ~rd_clk;

    cfifo_cascade u0 (
        .wr_clk(wr_clk), .relay_clk(relay_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
    );

    int unsigned tests = 0, fails = 0;
    logic [15:0] q[$];
    int unsigned acc = 0, rcount = 0;
    logic [15:0] next_val = 16'h1000;
    int wr_mode = 0, rd_mode = 0;
    bit running = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // writer: modes 0 idle, 1 always, 2 random 3/4, 3 one word then idle
    initial begin
        wait (running);
        forever begin
            @(negedge wr_clk);
            chk(full || q.size() < CAP, "R4 full low with 3073 unread", q.size(), CAP - 1);
            case (wr_mode)
                1:       wr_en = 1'b1;
                2:       wr_en = ($urandom % 4) != 0;
                3:       wr_en = 1'b1;
                default: wr_en = 1'b0;
            endcase
            wr_data = next_val;
            if (wr_en && !full) begin
                q.push_back(next_val);
                next_val = next_val + 16'd1;
                acc++;
                if (wr_mode == 3) wr_mode = 0;
            end
        end
    end

    // reader: modes 0 idle, 1 always, 2 random 1/2, 4 sparse 1/8
    initial begin
        logic [15:0] exp_q = '0;
        logic [15:0] pend = '0;
        bit          pv = 0;
        wait (running);
        forever begin
            @(negedge rd_clk);
            if (pv) exp_q = pend;
            pv = 0;
            chk(rd_data == exp_q, empty ? "R3 rd_data held" : "R1 R7 order/data",
                rd_data, exp_q);
            if (!empty)
                chk(q.size() > 0, "R5 empty low with nothing unread", q.size(), 1);
            case (rd_mode)
                1:       rd_en = 1'b1;
                2:       rd_en = ($urandom % 2) != 0;
                4:       rd_en = ($urandom % 8) == 0;
                default: rd_en = 1'b0;
            endcase
            if (rd_en && !empty && q.size() > 0) begin
                pend = q.pop_front();
                pv   = 1;
                rcount++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge wr_clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic drain_all();
        int n = 0;
        wr_mode = 0;
        rd_mode = 1;
        while (rcount != acc && n < 30000) begin @(negedge rd_clk); n++; end
        repeat (50) @(negedge rd_clk);
        chk(rcount == acc, "R9 every word crossed both stages", rcount, acc);
        chk(empty == 1'b1, "R5 empty after drain", empty, 1);
    endtask

    initial begin
        int n;
        int base;
        repeat (10) @(negedge wr_clk);
        rst_n = 1;
        repeat (6) @(negedge rd_clk);
        chk(full == 1'b0, "R6 full after reset", full, 0);
        chk(empty == 1'b1, "R6 empty after reset", empty, 1);
        chk(rd_data == 16'h0, "R6 rd_data after reset", rd_data, 0);
        running = 1;

        // fill with reads stalled, keep writing into full
        wr_mode = 1;
        n = 0;
        while (acc < CAP && n < 8000) begin @(negedge wr_clk); n++; end
        repeat (300) @(negedge wr_clk);
        chk(acc == CAP, "R4 capacity with reads stalled", acc, CAP);
        chk(full == 1'b1, "R2 full held after overfill", full, 1);

        // drain, then keep reading while empty
        drain_all();
        rd_mode = 1;
        repeat (100) @(negedge rd_clk);
        chk(empty == 1'b1, "R2 overflow words never appear", empty, 1);
        chk(q.size() == 0, "R3 nothing consumed while empty", q.size(), 0);

        // single-word latency
        rd_mode = 0;
        wr_mode = 3;
        n = 0;
        @(negedge rd_clk);
        while (empty && n < 100) begin @(negedge rd_clk); n++; end
        chk(n <= 40, "R8 first-word latency", n, 40);
        drain_all();

        // random traffic both sides
        base = acc;
        wr_mode = 2;
        rd_mode = 2;
        n = 0;
        while (acc < base + 15000 && n < 60000) begin @(negedge wr_clk); n++; end
        drain_all();

        // write-heavy traffic near the full boundary
        wr_mode = 2;
        rd_mode = 4;
        repeat (12000) @(negedge wr_clk);
        chk(full == 1'b1, "R4 full reached under sparse reads", full, 1);
        drain_all();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule